// File: doc/BRIEF.md
# Segment remapping cache lookup

This block sits in a memory controller that pools a fast memory and a four-times larger slow memory into one flat address space. Data moves between the two in fixed 2 KB segments. Five segments compete for each fast-memory slot: one whose home is the fast slot and four whose homes are slow slots. A remapping entry records where each of those five segments currently lives. The block takes a physical address from the page tables and returns the device address where the segment really sits. It also flags whether that address is in fast memory.

Entries are held in a small 4-way set-associative cache with LRU replacement. The entry that owns a segment is picked by fixed address bits, so a miss always costs exactly one read of the remapping table in fast memory. That read returns an aligned pair of neighbouring entries, covering 4 KB, and both are allocated together as one cache line. A side port lets the swap engine overwrite a cached entry. Such a line becomes dirty and is written back to the table before its way is reused.

Top module: `srm_lookup`

## Requirements
- R1: After reset the block holds `req_ready` high and keeps `out_valid` and `mem_req_valid` low. The cache starts empty, so the first non-bypass lookup issues a table read.
- R2: An input address splits, from the top down, into a 3-bit group G, a 6-bit entry index I and an 11-bit offset. The result is {L, I, offset}, where L is the decoded location of group G. `out_fast` is 1 exactly when L is 0, which is the fast slot.
- R3: An entry is 20 bits. Bits [3k+2:3k] give the location of group k for k = 0 to 3, and bits [19:12] are a counter that does not affect translation. Group 4 sits at the one value in 0 to 4 that none of the four fields holds.
- R4: A lookup that hits produces `out_valid` in the cycle after it is accepted, and makes no memory request.
- R5: A miss issues one read with `mem_req_pidx` = I>>1. The response carries entry 2P in bits [19:0] and entry 2P+1 in bits [39:20]. Both entries are allocated, so a following lookup of the neighbouring index hits.
- R6: While a miss is being served, `req_ready` stays low. The translated result appears in the cycle after the read response.
- R7: Each set has 4 ways. A miss fills an invalid way if one exists, and otherwise replaces the least recently used way. Hits and fills both count as uses.
- R8: An address whose group field is 5, 6 or 7 is a sampling access. It returns `out_addr` equal to the input address with `out_fast` = 0, in the next cycle. It makes no memory request and leaves the cache unchanged.
- R9: An update (`upd_valid`) whose index is cached replaces that entry, so later lookups decode the new value. An update whose index is not cached is ignored. `req_ready` is low while `upd_valid` is high.
- R10: Replacing a line that was updated first issues a write of the whole line (same pair layout, `mem_req_write` = 1) to its pair address. The read for the new line follows. Clean lines are replaced without a write.
- R11: No set ever holds two valid ways with the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_addr | input | 20 | Page-table physical address |
| out_valid | output | 1 | Translation result valid (one cycle) |
| out_addr | output | 20 | Device address |
| out_fast | output | 1 | Device address lies in the fast slot |
| upd_valid | input | 1 | Entry update from the swap engine |
| upd_idx | input | 6 | Entry index being updated |
| upd_entry | input | 20 | New entry value |
| mem_req_valid | output | 1 | Table access request |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_ready | input | 1 | Table port accepts the request |
| mem_req_pidx | output | 5 | Entry-pair address in the table |
| mem_req_wdata | output | 40 | Line written back |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 40 | Entry pair returned by the table |

## Verification
The bench seeds the table with permuted entries, so that a hit can still point into slow memory and group 4 must be inferred. A decoder that read the wrong field, or that treated a hit as fast, would return the wrong slot. It fills one set past its four ways after re-touching the oldest line. This shows whether the victim is the least recently used way rather than a fixed or oldest-filled one. It drives an update to a cached entry and to an uncached one, then forces the updated line out. A design that dropped the dirty mark, wrote the wrong half or pair address, or applied an update to an uncached index would read back stale or corrupted locations. It also checks that sampling addresses pass through untouched and that neighbouring indices hit after one fill.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int GRP_W  = 3;
  localparam int TAG_N  = 4;
  localparam int CNT_W  = 8;
  localparam int ENT_W  = GRP_W * TAG_N + CNT_W;

  typedef logic [ENT_W-1:0] ent_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RD, ST_WAIT} st_t;

  // location (0 = fast slot, 1..4 = slow slots) of a segment group
  function automatic logic [GRP_W-1:0] loc_of(ent_t e, logic [GRP_W-1:0] grp);
    logic [4:0]       used;
    logic [GRP_W-1:0] t;
    logic [GRP_W-1:0] r;
    used = '0;
    for (int i = 0; i < TAG_N; i++) begin
      t = e[GRP_W*i +: GRP_W];
      if (t < 3'd5) used[t] = 1'b1;
    end
    r = 3'd4;
    for (int k = 4; k >= 0; k--)
      if (!used[k]) r = GRP_W'(k);
    case (grp)
      3'd0: r = e[2:0];
      3'd1: r = e[5:3];
      3'd2: r = e[8:6];
      3'd3: r = e[11:9];
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/srm_decode.sv
module srm_decode
  import srm_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int SEG_W = 11,
  localparam int ADDR_W = GRP_W + IDX_W + SEG_W
) (
  input  logic [ADDR_W-1:0] ptpa,
  input  ent_t              ent,
  output logic [ADDR_W-1:0] dev,
  output logic              fast
);
  logic [GRP_W-1:0] loc;

  always_comb begin
    loc  = loc_of(ent, ptpa[ADDR_W-1 -: GRP_W]);
    dev  = {loc, ptpa[ADDR_W-GRP_W-1:0]};
    fast = (loc == '0);
  end
endmodule

// File: rtl/srm_lru.sv
module srm_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] old_way
);
  logic [WAY_W-1:0] age [SETS][WAYS];
  logic [WAYS-1:0]  is_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    old_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      is_old[w] = (age[q_set][w] == WAY_W'(WAYS-1));
      if (is_old[w]) old_way = WAY_W'(w);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1); // R7
endmodule

// File: rtl/srm_lookup.sv
module srm_lookup
  import srm_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int SEG_W = 11,
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  localparam int ADDR_W = GRP_W + IDX_W + SEG_W,
  localparam int PIDX_W = IDX_W - 1,
  localparam int LINE_W = 2 * ENT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fast,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [ENT_W-1:0]  upd_entry,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  input  logic              mem_req_ready,
  output logic [PIDX_W-1:0] mem_req_pidx,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAGF_W = PIDX_W - SET_W;

  st_t st;
  logic [ADDR_W-1:0] pend_addr, lk_addr;
  logic [SETS-1:0][WAYS-1:0] lv, ld;
  logic [TAGF_W-1:0] ltag [SETS][WAYS];
  logic [LINE_W-1:0] ldat [SETS][WAYS];

  logic [GRP_W-1:0]  lk_grp;
  logic [IDX_W-1:0]  lk_idx;
  logic [PIDX_W-1:0] lk_pidx, u_pidx;
  logic [SET_W-1:0]  lk_set, u_set;
  logic [TAGF_W-1:0] lk_tag, u_tag;
  logic              lk_byp;
  logic [WAYS-1:0]   hit_vec, uhit_vec;
  logic [WAY_W-1:0]  hit_way, uhit_way, vic_way, lru_way, vic_q;
  logic [LINE_W-1:0] dec_line;
  ent_t              dec_ent;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_fast;
  // named events for checking
  logic acc, acc_byp, acc_hit, acc_miss, fill_evt, upd_evt;

  assign lk_addr = (st == ST_IDLE) ? req_addr : pend_addr;
  assign lk_grp  = lk_addr[ADDR_W-1 -: GRP_W];
  assign lk_idx  = lk_addr[SEG_W +: IDX_W];
  assign lk_pidx = lk_idx[IDX_W-1:1];
  assign lk_set  = lk_pidx[SET_W-1:0];
  assign lk_tag  = lk_pidx[PIDX_W-1:SET_W];
  assign lk_byp  = lk_grp > 3'd4;
  assign u_pidx  = upd_idx[IDX_W-1:1];
  assign u_set   = u_pidx[SET_W-1:0];
  assign u_tag   = u_pidx[PIDX_W-1:SET_W];

  always_comb begin
    hit_way  = '0;
    uhit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w]  = lv[lk_set][w] && (ltag[lk_set][w] == lk_tag);
      uhit_vec[w] = lv[u_set][w] && (ltag[u_set][w] == u_tag);
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (uhit_vec[w]) uhit_way = WAY_W'(w);
    end
    vic_way = lru_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!lv[lk_set][w]) vic_way = WAY_W'(w);
  end

  assign dec_line = (st == ST_WAIT) ? mem_rsp_data : ldat[lk_set][hit_way];
  assign dec_ent  = lk_idx[0] ? dec_line[LINE_W-1:ENT_W] : dec_line[ENT_W-1:0];

  srm_decode #(.IDX_W(IDX_W), .SEG_W(SEG_W)) u_dec (
    .ptpa(lk_addr), .ent(dec_ent), .dev(dec_addr), .fast(dec_fast));

  srm_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(acc_hit || fill_evt),
    .touch_set(lk_set), .touch_way(fill_evt ? vic_q : hit_way),
    .q_set(lk_set), .old_way(lru_way));

  assign req_ready = (st == ST_IDLE) && !upd_valid;
  assign acc       = req_valid && req_ready;
  assign acc_byp   = acc && lk_byp;
  assign acc_hit   = acc && !lk_byp && (|hit_vec);
  assign acc_miss  = acc && !lk_byp && !(|hit_vec);
  assign fill_evt  = (st == ST_WAIT) && mem_rsp_valid;
  assign upd_evt   = (st == ST_IDLE) && upd_valid && (|uhit_vec);

  assign mem_req_valid = (st == ST_WB) || (st == ST_RD);
  assign mem_req_write = (st == ST_WB);
  assign mem_req_pidx  = (st == ST_WB) ? {ltag[lk_set][vic_q], lk_set} : lk_pidx;
  assign mem_req_wdata = ldat[lk_set][vic_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend_addr <= '0;
      vic_q     <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fast  <= 1'b0;
      lv        <= '0;
      ld        <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (upd_evt) begin
            ld[u_set][uhit_way] <= 1'b1;
          end else if (acc_byp) begin
            out_valid <= 1'b1;
            out_addr  <= req_addr;
            out_fast  <= 1'b0;
          end else if (acc_hit) begin
            out_valid <= 1'b1;
            out_addr  <= dec_addr;
            out_fast  <= dec_fast;
          end else if (acc_miss) begin
            pend_addr <= req_addr;
            vic_q     <= vic_way;
            st <= (lv[lk_set][vic_way] && ld[lk_set][vic_way]) ? ST_WB : ST_RD;
          end
        end
        ST_WB:   if (mem_req_ready) st <= ST_RD;
        ST_RD:   if (mem_req_ready) st <= ST_WAIT;
        default: begin
          if (mem_rsp_valid) begin
            lv[lk_set][vic_q] <= 1'b1;
            ld[lk_set][vic_q] <= 1'b0;
            out_valid <= 1'b1;
            out_addr  <= dec_addr;
            out_fast  <= dec_fast;
            st        <= ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (upd_evt) begin
      if (upd_idx[0]) ldat[u_set][uhit_way][LINE_W-1:ENT_W] <= upd_entry;
      else            ldat[u_set][uhit_way][ENT_W-1:0]      <= upd_entry;
    end else if (fill_evt) begin
      ltag[lk_set][vic_q] <= lk_tag;
      ldat[lk_set][vic_q] <= mem_rsp_data;
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byp |=> out_valid && !out_fast && out_addr == $past(req_addr)); // R8
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> out_valid && !mem_req_valid); // R4
  AST_FILL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> out_valid && req_ready == !upd_valid); // R6
  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> mem_req_valid && !mem_req_write); // R10
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R11
  AST_FAST_IS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fast) |-> out_addr[ADDR_W-1 -: GRP_W] == '0); // R2
endmodule

// File: tb/sim_srm_lookup.sv
`timescale 1ns/1ps
module sim_srm_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [19:0] req_addr = '0;
  logic out_valid, out_fast;
  logic [19:0] out_addr;
  logic upd_valid = 1'b0;
  logic [5:0] upd_idx = '0;
  logic [19:0] upd_entry = '0;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [4:0] mem_req_pidx;
  logic [39:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [39:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  srm_lookup u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_fast(out_fast), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_entry(upd_entry), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_ready(mem_req_ready),
    .mem_req_pidx(mem_req_pidx), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [19:0] mem_e [64];   // table held in fast memory
  logic [19:0] view  [64];   // entry the block should decode
  logic [19:0] got_addr;
  logic got_fast, got_ok, busy_rdy;
  int n_rd, n_wr, rd_pidx, wr_pidx, rsp_gap;
  logic [39:0] wr_data;

  function automatic logic [19:0] mk(int g, int idx, int off);
    return {3'(g), 6'(idx), 11'(off)};
  endfunction

  function automatic logic [19:0] ent(int l0, int l1, int l2, int l3, int c);
    return {8'(c), 3'(l3), 3'(l2), 3'(l1), 3'(l0)};
  endfunction

  // own restatement: the missing location is 10 minus the sum of the four present
  function automatic logic [2:0] ref_loc(logic [19:0] e, int g);
    int t [4];
    for (int k = 0; k < 4; k++) t[k] = int'(e[3*k +: 3]);
    if (g < 4) return 3'(t[g]);
    return 3'(10 - t[0] - t[1] - t[2] - t[3]);
  endfunction

  function automatic logic [19:0] ref_dev(logic [19:0] a);
    int g = int'(a[19:17]);
    if (g > 4) return a;
    return {ref_loc(view[a[16:11]], g), a[16:0]};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] a);
    bit pend = 0;
    int c_rsp = -10;
    n_rd = 0; n_wr = 0; got_ok = 0; busy_rdy = 0; rsp_gap = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      mem_rsp_valid = 1'b0;
      if (out_valid) begin
        got_ok = 1; got_addr = out_addr; got_fast = out_fast; rsp_gap = c - c_rsp;
        break;
      end
      if (req_ready) busy_rdy = 1;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = {mem_e[2*rd_pidx+1], mem_e[2*rd_pidx]};
        pend = 0; c_rsp = c;
      end else if (mem_req_valid) begin
        if (mem_req_write) begin
          n_wr++;
          wr_pidx = int'(mem_req_pidx);
          wr_data = mem_req_wdata;
          mem_e[2*wr_pidx]   = mem_req_wdata[19:0];
          mem_e[2*wr_pidx+1] = mem_req_wdata[39:20];
        end else begin
          n_rd++;
          rd_pidx = int'(mem_req_pidx);
          pend = 1;
        end
      end
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
  endtask

  task automatic run(input string rq, input logic [19:0] a, input int exp_rd, input int exp_wr);
    logic [19:0] ex = ref_dev(a);
    logic exf = (a[19:17] <= 3'd4) && (ex[19:17] == 3'd0);
    lookup(a);
    chk(rq, "result seen", 64'(got_ok), 64'd1);
    chk(rq, "out_addr", 64'(got_addr), 64'(ex));
    chk(rq, "out_fast", 64'(got_fast), 64'(exf));
    chk(rq, "reads", 64'(n_rd), 64'(exp_rd));
    chk(rq, "writes", 64'(n_wr), 64'(exp_wr));
    if (exp_rd > 0) begin
      chk("R5", "read pair addr", 64'(rd_pidx), 64'(a[16:12]));
      chk("R6", "ready held low", 64'(busy_rdy), 64'd0);
      chk("R6", "result after response", 64'(rsp_gap), 64'd1);
    end
  endtask

  task automatic update(input int idx, input logic [19:0] e, input bit cached);
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = 6'(idx); upd_entry = e;
    #1;
    chk("R9", "ready low during update", 64'(req_ready), 64'd0);
    @(negedge clk);
    upd_valid = 1'b0;
    if (cached) view[idx] = e;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    run("R1", mk(2, 2, 11'h010), 1, 0);   // empty cache: miss
  endtask

  task automatic t_decode;
    run("R3", mk(0, 2, 11'h7FF), 0, 0);   // slow slot 4, hit
    run("R3", mk(4, 2, 11'h123), 0, 0);   // inferred group 4
    run("R5", mk(4, 3, 11'h001), 0, 0);   // neighbour hits after one fill
    run("R2", mk(1, 3, 11'h400), 0, 0);   // fast
    run("R2", mk(3, 5, 11'h055), 1, 0);   // identity entry, slow slot 3
    run("R4", mk(0, 4, 11'h2AA), 0, 0);   // neighbour of index 5 hits
  endtask

  task automatic t_bypass;
    run("R8", mk(5, 9, 11'h0F0), 0, 0);
    run("R8", mk(6, 40, 11'h3C3), 0, 0);
    run("R8", mk(7, 63, 11'h7FF), 0, 0);
    run("R8", mk(0, 2, 11'h00F), 0, 0);   // cache unchanged
  endtask

  task automatic t_lru;   // set 0: indices 0, 8, 16, 24, 32 map there
    run("R7", mk(0, 0, 1), 1, 0);
    run("R7", mk(0, 8, 2), 1, 0);
    run("R7", mk(0, 16, 3), 1, 0);
    run("R7", mk(0, 24, 4), 1, 0);
    run("R5", mk(2, 1, 5), 0, 0);         // touches line of index 0
    run("R7", mk(1, 32, 6), 1, 0);        // evicts index 8's line
    run("R7", mk(0, 0, 7), 0, 0);
    run("R7", mk(3, 8, 8), 1, 0);         // evicts index 16's line
    run("R7", mk(4, 24, 9), 0, 0);
  endtask

  task automatic t_update;
    update(24, ent(1, 0, 2, 3, 8'h3C), 1'b1);
    run("R9", mk(0, 24, 11'h111), 0, 0);  // now slow slot 1
    run("R9", mk(1, 24, 11'h222), 0, 0);  // now fast
    update(16, ent(4, 3, 2, 1, 8'hEE), 1'b0);  // not cached: ignored
    run("R9", mk(0, 16, 11'h333), 1, 0);  // evicts clean line
    run("R10", mk(0, 40, 11'h044), 1, 0);
    run("R10", mk(0, 48, 11'h055), 1, 0);
    run("R10", mk(0, 56, 11'h066), 1, 1); // dirty line of pair 12 leaves
    chk("R10", "write pair addr", 64'(wr_pidx), 64'd12);
    chk("R10", "write data", 64'(wr_data), 64'({view[25], view[24]}));
    run("R10", mk(0, 24, 11'h077), 1, 0); // table now holds the update
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_e[i] = ent(0, 1, 2, 3, i * 3);
    mem_e[2] = ent(4, 2, 0, 1, 8'hA5);
    mem_e[3] = ent(3, 0, 4, 2, 8'h5A);
    for (int i = 0; i < 64; i++) view[i] = mem_e[i];
    t_reset();
    t_decode();
    t_bypass();
    t_lru();
    t_update();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule